// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets software reach the management registers of an external Ethernet PHY over a two-wire MDC/MDIO bus using Clause 45 framing. Software sees two 32-bit registers on a simple write-strobe / combinational-read bus. The first register holds the target: the PHY port, the MMD device and the 16-bit register number. The second register holds the operation, the write payload, the MDC rate select, an address-mode flag and a busy bit. Setting the busy bit starts the access.

Every command produces two frames back to back. The first is an address frame that loads the register number into the PHY. The second carries a write, a read, or a read with post-increment. During the data part of a read frame the master releases MDIO, and it shifts the PHY's bits in on rising MDC edges. When the sequence ends, busy clears and any read result appears in the low half of the command register. MDC is derived from the system clock by a programmable divider.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset both registers read 0, MDC is low and MDIO is released (`mdio_oe` = 0).
- R2: The target register at offset 0x11200 reads back {6'b0, device[25:21], port[20:16], regnum[15:0]}. The command register at offset 0x11204 reads back {9'b0, busy[22], rate[21:19], amode[18], op[17:16], data[15:0]}. Unused bits read 0.
- R3: A command-register write with bit 22 set starts a transaction, and busy reads 1 until the transaction ends. A write with bit 22 clear only stores the fields and produces no MDC activity.
- R4: Each non-reserved command sends 128 MDC cycles as two 64-bit frames, each sent MSB first. Frame 1 is 32 ones, 00, 00, port, device, 10, regnum. Frame 2 is 32 ones, 00, opcode, port, device, 10, then the payload. The opcode is 01 for op 1 (write), 10 for op 2 (read with post-increment) and 11 for op 3 (read).
- R5: After a read (op 2 or 3), bits 15:0 of the command register hold the 16 bits sampled from MDIO in frame-2 bit positions 48..63, first bit received in bit 15.
- R6: MDIO is driven during every frame bit except frame-2 positions 47..63 of a read, where it is released. MDIO output and enable change only while MDC is low.
- R7: Op 0 (reserved) with bit 22 set holds busy for exactly one cycle and produces no MDC edge.
- R8: While busy is 1, writes to either register are ignored. The transaction in flight and the register contents are unchanged.
- R9: The MDC high and low phases each last 8·2^rate system clocks, where rate is the 3-bit field.
- R10: Between transactions MDC is low and MDIO is released. Busy clears on the same clock edge as the final falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = driving) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest situation to reach is the read frame's turnaround, where drive must stop exactly one bit before the PHY's data begins. The PHY must return data on the right falling MDC edges even though the input passes through a synchroniser first. The bench contains a PHY model that counts rising MDC edges. It drives a zero turnaround bit and then a chosen 16-bit pattern, and it checks the output enable at every rising edge against the expected release window. The busy-lock case is reached by issuing conflicting register writes partway through a running frame and then comparing the captured frames against the original command.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

   // opcode field values in the command register
   localparam logic [1:0] OPC_RSVD   = 2'd0;
   localparam logic [1:0] OPC_WRITE  = 2'd1;
   localparam logic [1:0] OPC_POSTRD = 2'd2;
   localparam logic [1:0] OPC_READ   = 2'd3;

   // target register field positions
   localparam int TGT_REG_LSB  = 0;
   localparam int TGT_PORT_LSB = 16;
   localparam int TGT_DEV_LSB  = 21;

   // command register field positions
   localparam int CMD_OP_LSB   = 16;
   localparam int CMD_AMODE    = 18;
   localparam int CMD_RATE_LSB = 19;
   localparam int CMD_BUSY     = 22;
   localparam int RATE_W       = 3;

   localparam int FRAME_BITS   = 64;
   localparam int TA2_POS      = 47;
   localparam int DATA_POS     = 48;

   // one Clause 45 frame, bit 63 sent first
   function automatic logic [63:0] c45_frame(input logic [1:0]  opc,
                                             input logic [4:0]  port,
                                             input logic [4:0]  dev,
                                             input logic [15:0] payload);
      return {32'hFFFF_FFFF, 2'b00, opc, port, dev, 2'b10, payload};
   endfunction

endpackage

// File: rtl/mdio_c45_clkdiv.sv
module mdio_c45_clkdiv #(
   parameter int BASE_HALF = 8,
   parameter int SEL_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
   localparam int CNT_W    = $clog2(MAX_HALF);
   localparam int HW       = CNT_W + 1;

   generate
      if (BASE_HALF < 2) begin : g_bad_half
         $error("BASE_HALF must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [HW-1:0]    half;

   always_comb half = HW'(BASE_HALF) << sel;
   assign tick = run && ({1'b0, cnt_q} == (half - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run || tick) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/mdio_c45_engine.sv
module mdio_c45_engine
   import mdio_c45_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [1:0]  op,
   input  logic [4:0]  port,
   input  logic [4:0]  dev,
   input  logic [15:0] regnum,
   input  logic [15:0] wdata,
   input  logic        tick,
   input  logic        mdio_i,
   output logic        running,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe
);
   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic din;
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign din = mdio_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], mdio_i} >> 0;
         end
         assign din = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   logic        run_q, mdc_q, frm_q;
   logic [5:0]  bit_q;
   logic [15:0] shf_q;
   logic [63:0] frame_w;
   logic        is_rd, last;

   assign is_rd   = op[1];
   assign frame_w = frm_q ? c45_frame(op, port, dev, is_rd ? 16'hFFFF : wdata)
                          : c45_frame(2'b00, port, dev, regnum);
   assign last    = frm_q && (bit_q == 6'd63);

   assign mdio_o  = frame_w[6'd63 - bit_q];
   assign mdio_oe = run_q && !(frm_q && is_rd && (bit_q >= 6'(TA2_POS)));
   assign mdc     = mdc_q;
   assign running = run_q;
   assign rd_data = shf_q;
   assign done    = (start && (op == OPC_RSVD)) || (run_q && tick && mdc_q && last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         mdc_q <= 1'b0;
         frm_q <= 1'b0;
         bit_q <= '0;
         shf_q <= '0;
      end else if (start && (op != OPC_RSVD)) begin
         run_q <= 1'b1;
         mdc_q <= 1'b0;
         frm_q <= 1'b0;
         bit_q <= '0;
      end else if (run_q && tick) begin
         if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (frm_q && is_rd && (bit_q >= 6'(DATA_POS)))
               shf_q <= {shf_q[14:0], din};
         end else begin
            mdc_q <= 1'b0;
            if (last) begin
               run_q <= 1'b0;
               frm_q <= 1'b0;
               bit_q <= '0;
            end else if (bit_q == 6'd63) begin
               frm_q <= 1'b1;
               bit_q <= '0;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   // R6
   mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc_q);

   // R9
   mdc_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdc_q) |-> $past(tick));
endmodule

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
   import mdio_c45_pkg::*;
#(
   parameter int              ADDR_W   = 20,
   parameter logic [ADDR_W-1:0] TGT_OFS = 'h11200,
   parameter logic [ADDR_W-1:0] CMD_OFS = 'h11204
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              done,
   input  logic [15:0]       rd_data,
   output logic              busy,
   output logic              start,
   output logic [1:0]        op,
   output logic [4:0]        port,
   output logic [4:0]        dev,
   output logic [15:0]       regnum,
   output logic [15:0]       data,
   output logic [RATE_W-1:0] rate
);
   generate
      if (TGT_OFS == CMD_OFS) begin : g_bad_ofs
         $error("register offsets must differ");
      end
   endgenerate

   logic              busy_q, start_q, amode_q;
   logic [1:0]        op_q;
   logic [4:0]        port_q, dev_q;
   logic [15:0]       reg_q, data_q;
   logic [RATE_W-1:0] rate_q;
   logic              unused_hi;

   assign unused_hi = ^reg_wdata[31:26];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         amode_q <= 1'b0;
         op_q    <= '0;
         port_q  <= '0;
         dev_q   <= '0;
         reg_q   <= '0;
         data_q  <= '0;
         rate_q  <= '0;
      end else begin
         start_q <= 1'b0;
         if (done) begin
            busy_q <= 1'b0;
            if (op_q[1]) data_q <= rd_data;
         end
         if (reg_wr && !busy_q) begin
            if (reg_addr == TGT_OFS) begin
               reg_q  <= reg_wdata[TGT_REG_LSB +: 16];
               port_q <= reg_wdata[TGT_PORT_LSB +: 5];
               dev_q  <= reg_wdata[TGT_DEV_LSB +: 5];
            end else if (reg_addr == CMD_OFS) begin
               data_q  <= reg_wdata[15:0];
               op_q    <= reg_wdata[CMD_OP_LSB +: 2];
               amode_q <= reg_wdata[CMD_AMODE];
               rate_q  <= reg_wdata[CMD_RATE_LSB +: RATE_W];
               if (reg_wdata[CMD_BUSY]) begin
                  busy_q  <= 1'b1;
                  start_q <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      if (reg_addr == TGT_OFS)
         reg_rdata = {6'b0, dev_q, port_q, reg_q};
      else if (reg_addr == CMD_OFS)
         reg_rdata = {9'b0, busy_q, rate_q, amode_q, op_q, data_q};
      else
         reg_rdata = '0;
   end

   assign busy   = busy_q;
   assign start  = start_q;
   assign op     = op_q;
   assign port   = port_q;
   assign dev    = dev_q;
   assign regnum = reg_q;
   assign data   = data_q;
   assign rate   = rate_q;

   // R7
   rsvd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && op_q == OPC_RSVD) |=> !busy_q);

   // R8
   locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && reg_wr) |=> ($stable(reg_q) && $stable(port_q) && $stable(dev_q)
                              && $stable(op_q) && $stable(rate_q) && $stable(amode_q)));
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
   import mdio_c45_pkg::*;
#(
   parameter int                ADDR_W      = 20,
   parameter logic [ADDR_W-1:0] TGT_OFS     = 'h11200,
   parameter logic [ADDR_W-1:0] CMD_OFS     = 'h11204,
   parameter int                BASE_HALF   = 8,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   logic              busy, start, done, running, tick;
   logic [1:0]        op;
   logic [4:0]        port, dev;
   logic [15:0]       regnum, data, rd_data;
   logic [RATE_W-1:0] rate;

   mdio_c45_regs #(.ADDR_W(ADDR_W), .TGT_OFS(TGT_OFS), .CMD_OFS(CMD_OFS)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done), .rd_data(rd_data),
      .busy(busy), .start(start), .op(op), .port(port), .dev(dev),
      .regnum(regnum), .data(data), .rate(rate));

   mdio_c45_clkdiv #(.BASE_HALF(BASE_HALF), .SEL_W(RATE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(running), .sel(rate), .tick(tick));

   mdio_c45_engine #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .port(port), .dev(dev),
      .regnum(regnum), .wdata(data), .tick(tick), .mdio_i(mdio_i),
      .running(running), .done(done), .rd_data(rd_data),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

// File: tb/mdio_c45_master_test.sv
`timescale 1ns/1ps
module mdio_c45_master_test;
   localparam logic [19:0] TGT = 20'h11200;
   localparam logic [19:0] CMD = 20'h11204;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   mdio_c45_master uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   // ---------------- PHY model ----------------
   logic [63:0] cap;
   logic [63:0] fr0, fr1;
   int          nrise, nedges, oe_bad;
   logic        phy_rd;
   logic [15:0] phy_pat;
   realtime     t_rise, t_fall, hi_ns;

   task automatic phy_clear();
      cap = '0; fr0 = '0; fr1 = '0;
      nrise = 0; nedges = 0; oe_bad = 0;
      mdio_i = 1'b1;
   endtask

   always @(posedge mdc) begin
      int idx;
      logic exp_oe;
      idx = nrise % 64;
      exp_oe = !(phy_rd && (nrise / 64 == 1) && idx >= 47);
      if (mdio_oe !== exp_oe) oe_bad++;
      cap = {cap[62:0], mdio_oe ? mdio_o : mdio_i};
      nrise++;
      if (nrise == 64)  fr0 = cap;
      if (nrise == 128) fr1 = cap;
      t_rise = $realtime;
      nedges++;
   end

   always @(negedge mdc) begin
      int idx;
      if (rst_n) begin
         nedges++;
         hi_ns = $realtime - t_rise;
         t_fall = $realtime;
         idx = nrise % 64;
         if (phy_rd && (nrise / 64 == 1) && idx >= 47)
            mdio_i = (idx == 47) ? 1'b0 : phy_pat[15 - (idx - 48)];
         else
            mdio_i = 1'b1;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [19:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 100000; i++) begin
         @(negedge clk);
         bus_read(CMD, v);
         if (!v[22]) break;
      end
   endtask

   function automatic logic [31:0] cmd_word(input logic go, input logic [2:0] rate,
                                            input logic am, input logic [1:0] op,
                                            input logic [15:0] d);
      return {9'b0, go, rate, am, op, d};
   endfunction

   function automatic logic [63:0] exp_frame(input logic [1:0] opc, input logic [4:0] p,
                                             input logic [4:0] dv, input logic [15:0] pl);
      return {32'hFFFF_FFFF, 2'b00, opc, p, dv, 2'b10, pl};
   endfunction

   task automatic start_cmd(input logic [4:0] p, input logic [4:0] dv, input logic [15:0] rn,
                            input logic [1:0] op, input logic [15:0] d, input logic [2:0] rate,
                            input logic [15:0] pat);
      logic [31:0] v;
      bus_write(TGT, {6'b0, dv, p, rn});
      phy_clear();
      phy_rd = op[1];
      phy_pat = pat;
      bus_write(CMD, cmd_word(1'b1, rate, 1'b0, op, d));
      bus_read(CMD, v);
      check(v[22] == 1'b1, "R3 busy after start", {63'b0, v[22]}, 64'd1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [31:0] v;
      bus_read(TGT, v);
      check(v == 0, "R1 target reg reset", v, 0);
      bus_read(CMD, v);
      check(v == 0, "R1 command reg reset", v, 0);
      check(mdc == 0 && mdio_oe == 0, "R1 bus idle at reset", {mdc, mdio_oe}, 0);
   endtask

   task automatic t_layout();
      logic [31:0] v;
      bus_write(TGT, 32'hFFFF_FFFF);
      bus_read(TGT, v);
      check(v == 32'h03FF_FFFF, "R2 target reg mask", v, 32'h03FF_FFFF);
      bus_write(TGT, {6'b0, 5'd7, 5'd19, 16'h1234});
      bus_read(TGT, v);
      check(v == {6'b0, 5'd7, 5'd19, 16'h1234}, "R2 target reg fields", v,
            {6'b0, 5'd7, 5'd19, 16'h1234});
   endtask

   task automatic t_no_start();
      logic [31:0] v;
      phy_clear();
      bus_write(CMD, 32'hFF80_0000 | cmd_word(1'b0, 3'd2, 1'b1, 2'd1, 16'hA5A5));
      repeat (60) @(negedge clk);
      bus_read(CMD, v);
      check(v == cmd_word(1'b0, 3'd2, 1'b1, 2'd1, 16'hA5A5), "R3 no start, fields stored",
            v, cmd_word(1'b0, 3'd2, 1'b1, 2'd1, 16'hA5A5));
      check(nedges == 0, "R3 no MDC edges without busy", nedges, 0);
   endtask

   task automatic t_write();
      logic [31:0] v;
      start_cmd(5'd1, 5'd30, 16'hC0DE, 2'd1, 16'h5A3C, 3'd0, 16'h0);
      wait_idle();
      check(nrise == 128, "R4 write MDC cycle count", nrise, 128);
      check(fr0 == exp_frame(2'b00, 5'd1, 5'd30, 16'hC0DE), "R4 address frame", fr0,
            exp_frame(2'b00, 5'd1, 5'd30, 16'hC0DE));
      check(fr1 == exp_frame(2'b01, 5'd1, 5'd30, 16'h5A3C), "R4 write frame", fr1,
            exp_frame(2'b01, 5'd1, 5'd30, 16'h5A3C));
      check(oe_bad == 0, "R6 drive enable during write", oe_bad, 0);
      check(hi_ns > 39.0 && hi_ns < 41.0, "R9 rate 0 half period ns", longint'(hi_ns), 40);
      check(mdc == 0 && mdio_oe == 0, "R10 idle after write", {mdc, mdio_oe}, 0);
      check(($realtime - t_fall) < 5.0, "R10 busy clears with last fall",
            longint'($realtime - t_fall), 2);
      bus_read(CMD, v);
      check(v == cmd_word(1'b0, 3'd0, 1'b0, 2'd1, 16'h5A3C), "R2 command readback after write",
            v, cmd_word(1'b0, 3'd0, 1'b0, 2'd1, 16'h5A3C));
   endtask

   task automatic t_read(input logic [1:0] op, input logic [15:0] pat, input string tag);
      logic [31:0] v;
      start_cmd(5'd0, 5'd1, 16'h0002, op, 16'h0000, 3'd0, pat);
      wait_idle();
      bus_read(CMD, v);
      check(v[15:0] == pat, {"R5 read data ", tag}, v[15:0], pat);
      check(fr1 == exp_frame(op, 5'd0, 5'd1, pat), {"R4 second frame ", tag}, fr1,
            exp_frame(op, 5'd0, 5'd1, pat));
      check(fr0 == exp_frame(2'b00, 5'd0, 5'd1, 16'h0002), {"R4 address frame ", tag}, fr0,
            exp_frame(2'b00, 5'd0, 5'd1, 16'h0002));
      check(oe_bad == 0, {"R6 release window ", tag}, oe_bad, 0);
   endtask

   task automatic t_reserved();
      logic [31:0] v;
      phy_clear();
      bus_write(CMD, cmd_word(1'b1, 3'd0, 1'b0, 2'd0, 16'h1111));
      bus_read(CMD, v);
      check(v[22] == 1'b1, "R7 reserved busy first cycle", v[22], 1);
      @(negedge clk);
      bus_read(CMD, v);
      check(v[22] == 1'b0, "R7 reserved busy cleared next cycle", v[22], 0);
      repeat (40) @(negedge clk);
      check(nedges == 0, "R7 reserved no MDC", nedges, 0);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      start_cmd(5'd3, 5'd5, 16'h00AA, 2'd1, 16'h9876, 3'd0, 16'h0);
      repeat (30) @(negedge clk);
      bus_write(TGT, {6'b0, 5'd31, 5'd31, 16'hFFFF});
      bus_write(CMD, cmd_word(1'b1, 3'd7, 1'b1, 2'd3, 16'h0F0F));
      wait_idle();
      bus_read(TGT, v);
      check(v == {6'b0, 5'd5, 5'd3, 16'h00AA}, "R8 target reg unchanged", v,
            {6'b0, 5'd5, 5'd3, 16'h00AA});
      check(fr0 == exp_frame(2'b00, 5'd3, 5'd5, 16'h00AA), "R8 address frame intact", fr0,
            exp_frame(2'b00, 5'd3, 5'd5, 16'h00AA));
      check(fr1 == exp_frame(2'b01, 5'd3, 5'd5, 16'h9876), "R8 data frame intact", fr1,
            exp_frame(2'b01, 5'd3, 5'd5, 16'h9876));
   endtask

   task automatic t_rate(input logic [2:0] rate);
      real exp_ns;
      start_cmd(5'd2, 5'd4, 16'h0010, 2'd1, 16'h0001, rate, 16'h0);
      wait_idle();
      exp_ns = 8.0 * (2 ** rate) * 5.0;
      check(hi_ns > exp_ns - 1.0 && hi_ns < exp_ns + 1.0, "R9 half period for rate select",
            longint'(hi_ns), longint'(exp_ns));
      check(nrise == 128, "R9 cycle count at slower rate", nrise, 128);
   endtask

   // ---------------- main ----------------
   initial begin
      phy_rd = 1'b0;
      phy_pat = '0;
      t_rise = 0; t_fall = 0; hi_ns = 0;
      phy_clear();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout();
      t_no_start();
      t_write();
      t_read(2'd3, 16'hB37C, "read");
      t_read(2'd3, 16'h8001, "read edges");
      t_read(2'd2, 16'h4E21, "post-incr read");
      t_reserved();
      t_lock();
      t_rate(3'd1);
      t_rate(3'd3);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual still running expected idle");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end
endmodule